// File: doc/BRIEF.md
# Role-Selectable Side-Stream Scrambler Generator

This block produces the side-stream scrambling sequence for a gigabit twisted-pair transmit coding path. It holds a single 33-bit linear feedback shift register. A link-role input picks the feedback polynomial: g(x) = 1 + x^13 + x^33 when the port is master, and g(x) = 1 + x^20 + x^33 when it is slave. The register advances once on every symbol clock, and its whole state is driven out.

Three 4-bit scrambling words are taken from that state by fixed XOR tap sets. Words X and Y feed the downstream scrambler-bit generator. Word G feeds the sign-nibble generator. The words are registered so that they always match the state shown on the same cycle.

A synchronous seed-load port sets the state. An all-zero seed would lock the register, so it is refused and the default seed is loaded in its place. The role is captured only in reset or during a load.

Top module: `sideScram`

## Requirements
- R1: Reset is synchronous and active low. On any clock edge with `rstN` low, `stateOut` becomes the default seed 33'h0_1F0F_5A3C and the role is captured from `roleSel` (1 = master, 0 = slave). Reset overrides a load.
- R2: In master role, on each edge with `rstN` high and `seedLoad` low, `stateOut` becomes {stateOut[31:0], stateOut[12] ^ stateOut[32]}.
- R3: In slave role, on each edge with `rstN` high and `seedLoad` low, `stateOut` becomes {stateOut[31:0], stateOut[19] ^ stateOut[32]}.
- R4: An edge with `rstN` high and `seedLoad` high loads a nonzero `seedVal` into `stateOut` and captures the role from `roleSel`. The load takes priority over the shift.
- R5: A load with `seedVal` equal to zero puts the default seed 33'h0_1F0F_5A3C into `stateOut` instead.
- R6: `roleSel` has no effect on edges that are neither reset nor load. The polynomial captured last stays in use.
- R7: On every cycle after reset, wordX[0]=s4^s6, wordX[1]=s7^s9^s12^s14, wordX[2]=s10^s12^s20^s22, and wordX[3]=s13^s15^s18^s20^s23^s25^s28^s30, where s is the `stateOut` of that same cycle.
- R8: On every cycle after reset, wordY[0]=s0, wordY[1]=s3^s8, wordY[2]=s6^s16, and wordY[3]=s9^s14^s19^s24, where s is the `stateOut` of that same cycle.
- R9: On every cycle after reset, wordG[0]=s1^s5, wordG[1]=s4^s8^s9^s13, wordG[2]=s7^s11^s17^s21, and wordG[3]=s10^s14^s19^s23^s25^s29, where s is the `stateOut` of that same cycle.
- R10: After reset, `stateOut` is never all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rstN | input | 1 | Synchronous active-low reset |
| roleSel | input | 1 | Link role: 1 master, 0 slave; captured at reset or load |
| seedLoad | input | 1 | Load `seedVal` on this edge |
| seedVal | input | 33 | Seed value to load |
| stateOut | output | 33 | Full register state, bits [32:0] |
| wordX | output | 4 | Scrambling word X for the scrambler-bit generator |
| wordY | output | 4 | Scrambling word Y for the scrambler-bit generator |
| wordG | output | 4 | Scrambling word G for the sign-nibble generator |

## Verification
The state is visible on the ports, so a bad feedback tap shows in stateOut[0] on the first edge after the tapped bit is set. Loading one-hot seeds at bits 12, 19 and 32 exposes each polynomial after a single shift. A wrongly captured role, or a role that follows `roleSel` while running, makes the state leave a bit-serial reference model within a few cycles of the change. A bad word tap, or a word register that lags by one cycle, breaks the same-cycle match between the words and `stateOut` on the very next edge.

// File: rtl/scram_pkg.sv
package scram_pkg;
  localparam int SCR_W  = 33;
  localparam int WORD_W = 4;

  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } scramRole_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeDefault;
    logic takeSeed;
    logic advance;
  } scramStrobe_t;

  // tap sets, one mask per word bit
  localparam logic [SCR_W-1:0] X_MASK [WORD_W] = '{
    33'h0_0000_0050, 33'h0_0000_5280, 33'h0_0050_1400, 33'h0_5294_A000};
  localparam logic [SCR_W-1:0] Y_MASK [WORD_W] = '{
    33'h0_0000_0001, 33'h0_0000_0108, 33'h0_0001_0040, 33'h0_0108_4200};
  localparam logic [SCR_W-1:0] G_MASK [WORD_W] = '{
    33'h0_0000_0022, 33'h0_0000_2310, 33'h0_0022_0880, 33'h0_2288_4400};
endpackage

// File: rtl/scramCtrl.sv
module scramCtrl
  import scram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             seedLoad,
  input  logic             roleSel,
  input  logic [SCR_W-1:0] seedVal,
  output scramStrobe_t     strobe,
  output scramRole_t       roleQ
);
  logic seedIsZero;

  assign seedIsZero = (seedVal == '0);

  always_comb begin
    strobe.takeDefault = !rstN || (seedLoad && seedIsZero);
    strobe.takeSeed    = rstN && seedLoad && !seedIsZero;
    strobe.advance     = rstN && !seedLoad;
  end

  // role is captured only in reset or during a load
  always_ff @(posedge clk) begin
    if (!rstN || seedLoad) roleQ <= scramRole_t'(roleSel);
  end
endmodule

// File: rtl/scramDatapath.sv
module scramDatapath
  import scram_pkg::*;
#(
  parameter int               MASTER_TAP   = 12,
  parameter int               SLAVE_TAP    = 19,
  parameter logic [SCR_W-1:0] DEFAULT_SEED = 33'h0_1F0F_5A3C
) (
  input  logic              clk,
  input  scramStrobe_t      strobe,
  input  scramRole_t        roleQ,
  input  logic [SCR_W-1:0]  seedVal,
  output logic [SCR_W-1:0]  stateQ,
  output logic [WORD_W-1:0] wordXQ,
  output logic [WORD_W-1:0] wordYQ,
  output logic [WORD_W-1:0] wordGQ
);
  localparam int TOP_BIT = SCR_W - 1;

  logic              fbBit;
  logic [SCR_W-1:0]  stateNext;
  logic [WORD_W-1:0] wordXNext, wordYNext, wordGNext;

  assign fbBit = stateQ[TOP_BIT] ^
                 ((roleQ == ROLE_MASTER) ? stateQ[MASTER_TAP] : stateQ[SLAVE_TAP]);

  always_comb begin
    if (strobe.takeDefault)   stateNext = DEFAULT_SEED;
    else if (strobe.takeSeed) stateNext = seedVal;
    else if (strobe.advance)  stateNext = {stateQ[TOP_BIT-1:0], fbBit};
    else                      stateNext = stateQ;
  end

  // words are formed from the next state so they line up with stateQ
  for (genvar b = 0; b < WORD_W; b++) begin : g_wordBit
    assign wordXNext[b] = ^(stateNext & X_MASK[b]);
    assign wordYNext[b] = ^(stateNext & Y_MASK[b]);
    assign wordGNext[b] = ^(stateNext & G_MASK[b]);
  end

  always_ff @(posedge clk) begin
    stateQ <= stateNext;
    wordXQ <= wordXNext;
    wordYQ <= wordYNext;
    wordGQ <= wordGNext;
  end
endmodule

// File: rtl/sideScram.sv
module sideScram
  import scram_pkg::*;
#(
  parameter int               MASTER_TAP   = 12,
  parameter int               SLAVE_TAP    = 19,
  parameter logic [SCR_W-1:0] DEFAULT_SEED = 33'h0_1F0F_5A3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              roleSel,
  input  logic              seedLoad,
  input  logic [SCR_W-1:0]  seedVal,
  output logic [SCR_W-1:0]  stateOut,
  output logic [WORD_W-1:0] wordX,
  output logic [WORD_W-1:0] wordY,
  output logic [WORD_W-1:0] wordG
);
  scramStrobe_t strobe;
  scramRole_t   roleQ;

  scramCtrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .seedLoad (seedLoad),
    .roleSel  (roleSel),
    .seedVal  (seedVal),
    .strobe   (strobe),
    .roleQ    (roleQ)
  );

  scramDatapath #(
    .MASTER_TAP   (MASTER_TAP),
    .SLAVE_TAP    (SLAVE_TAP),
    .DEFAULT_SEED (DEFAULT_SEED)
  ) i_dp (
    .clk     (clk),
    .strobe  (strobe),
    .roleQ   (roleQ),
    .seedVal (seedVal),
    .stateQ  (stateOut),
    .wordXQ  (wordX),
    .wordYQ  (wordY),
    .wordGQ  (wordG)
  );
endmodule

// File: rtl/sideScramChk.sv
module sideScramChk
  import scram_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              seedLoad,
  input logic [SCR_W-1:0]  seedVal,
  input logic [SCR_W-1:0]  stateOut,
  input logic [WORD_W-1:0] wordX,
  input logic [WORD_W-1:0] wordY,
  input logic [WORD_W-1:0] wordG,
  input scramRole_t        roleQ
);
  function automatic logic [WORD_W-1:0] maskWord(
      input logic [SCR_W-1:0] s, input logic [SCR_W-1:0] m [WORD_W]);
    logic [WORD_W-1:0] w;
    for (int b = 0; b < WORD_W; b++) w[b] = ^(s & m[b]);
    return w;
  endfunction

  assert_master_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(seedLoad) && $past(roleQ) == ROLE_MASTER) |->
      stateOut == {$past(stateOut[31:0]), $past(stateOut[12] ^ stateOut[32])});

  assert_slave_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(seedLoad) && $past(roleQ) == ROLE_SLAVE) |->
      stateOut == {$past(stateOut[31:0]), $past(stateOut[19] ^ stateOut[32])});

  assert_seed_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(seedLoad) && $past(seedVal) != '0) |->
      stateOut == $past(seedVal));

  assert_zero_seed_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(seedLoad) && $past(seedVal) == '0) |->
      stateOut == 33'h0_1F0F_5A3C);

  assert_role_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !seedLoad) |=> $stable(roleQ));

  always @(negedge clk) begin
    if (rstN && $past(rstN)) begin
      assert_word_x_R7: assert (wordX == maskWord(stateOut, X_MASK));
      assert_word_y_R8: assert (wordY == maskWord(stateOut, Y_MASK));
      assert_word_g_R9: assert (wordG == maskWord(stateOut, G_MASK));
      assert_nonzero_R10: assert (stateOut != '0);
    end
  end
endmodule

bind sideScram sideScramChk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .seedLoad (seedLoad),
  .seedVal  (seedVal),
  .stateOut (stateOut),
  .wordX    (wordX),
  .wordY    (wordY),
  .wordG    (wordG),
  .roleQ    (roleQ)
);

// File: tb/test_sideScram.sv
module test_sideScram;
  localparam logic [32:0] DEF_SEED = 33'h0_1F0F_5A3C;
  localparam int RUN_LEN = 4000;

  typedef struct packed {
    logic        role;
    logic [32:0] seed;
    logic [32:0] after;
  } vec_t;

  // one-hot and paired seeds: tap response after a single shift
  localparam vec_t VECS [8] = '{
    '{1'b1, 33'h1_0000_0000, 33'h0_0000_0001},
    '{1'b0, 33'h1_0000_0000, 33'h0_0000_0001},
    '{1'b1, 33'h0_0000_1000, 33'h0_0000_2001},
    '{1'b0, 33'h0_0000_1000, 33'h0_0000_2000},
    '{1'b1, 33'h0_0008_0000, 33'h0_0010_0000},
    '{1'b0, 33'h0_0008_0000, 33'h0_0010_0001},
    '{1'b1, 33'h1_0000_1000, 33'h0_0000_2000},
    '{1'b0, 33'h1_0000_1000, 33'h0_0000_2001}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        roleSel = 1'b1;
  logic        seedLoad = 1'b0;
  logic [32:0] seedVal = '0;
  logic [32:0] stateOut;
  logic [3:0]  wordX, wordY, wordG;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sideScram i_sideScram (
    .clk(clk), .rstN(rstN), .roleSel(roleSel), .seedLoad(seedLoad),
    .seedVal(seedVal), .stateOut(stateOut), .wordX(wordX), .wordY(wordY),
    .wordG(wordG)
  );

  function automatic logic [32:0] refStep(input logic [32:0] s, input logic master);
    logic fb;
    fb = s[32] ^ (master ? s[12] : s[19]);
    return {s[31:0], fb};
  endfunction

  function automatic logic [3:0] refX(input logic [32:0] s);
    return {s[13]^s[15]^s[18]^s[20]^s[23]^s[25]^s[28]^s[30],
            s[10]^s[12]^s[20]^s[22], s[7]^s[9]^s[12]^s[14], s[4]^s[6]};
  endfunction
  function automatic logic [3:0] refY(input logic [32:0] s);
    return {s[9]^s[14]^s[19]^s[24], s[6]^s[16], s[3]^s[8], s[0]};
  endfunction
  function automatic logic [3:0] refG(input logic [32:0] s);
    return {s[10]^s[14]^s[19]^s[23]^s[25]^s[29],
            s[7]^s[11]^s[17]^s[21], s[4]^s[8]^s[9]^s[13], s[1]^s[5]};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req,
                       input logic [32:0] act, input logic [32:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkWords(input string tag);
    check(wordX == refX(stateOut), {"R7 ", tag}, 33'(wordX), 33'(refX(stateOut)));
    check(wordY == refY(stateOut), {"R8 ", tag}, 33'(wordY), 33'(refY(stateOut)));
    check(wordG == refG(stateOut), {"R9 ", tag}, 33'(wordG), 33'(refG(stateOut)));
  endtask

  task automatic loadSeed(input logic role, input logic [32:0] seed);
    roleSel = role; seedLoad = 1'b1; seedVal = seed;
    tick();
    seedLoad = 1'b0;
  endtask

  // long run against the bit-serial model; flips roleSel halfway (R6)
  task automatic refRun(input logic master, input logic [32:0] seed, input string req);
    logic [32:0] refS;
    int errs;
    logic [32:0] firstAct, firstExp;
    errs = 0; firstAct = '0; firstExp = '0;
    loadSeed(master, seed);
    refS = seed;
    for (int i = 0; i < RUN_LEN; i++) begin
      if (i == RUN_LEN/2) roleSel = ~master;
      tick();
      refS = refStep(refS, master);
      if (stateOut !== refS || wordX !== refX(refS) || wordY !== refY(refS)
          || wordG !== refG(refS) || stateOut == '0) begin
        if (errs == 0) begin firstAct = stateOut; firstExp = refS; end
        errs++;
      end
    end
    check(errs == 0, {req, " R6 R7 R8 R9 R10 long run"}, firstAct, firstExp);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state, reset wins over a load
    seedLoad = 1'b1; seedVal = 33'h0_0000_0ABC;
    tick(); tick();
    seedLoad = 1'b0;
    check(stateOut == DEF_SEED, "R1 reset seed", stateOut, DEF_SEED);
    rstN = 1'b1;
    roleSel = 1'b0;  // ignored (R6): master captured in reset
    tick();
    check(stateOut == refStep(DEF_SEED, 1'b1), "R1 R2 R6 first shift master",
          stateOut, refStep(DEF_SEED, 1'b1));
    checkWords("after reset");

    // table: R4 load then single-shift tap response (R2/R3)
    for (int k = 0; k < 8; k++) begin
      loadSeed(VECS[k].role, VECS[k].seed);
      check(stateOut == VECS[k].seed, "R4 seed load", stateOut, VECS[k].seed);
      roleSel = ~VECS[k].role;
      tick();
      check(stateOut == VECS[k].after, VECS[k].role ? "R2 master tap" : "R3 slave tap",
            stateOut, VECS[k].after);
      checkWords("table");
    end

    // R5: zero seed replaced
    loadSeed(1'b0, '0);
    check(stateOut == DEF_SEED, "R5 zero seed", stateOut, DEF_SEED);
    tick();
    check(stateOut == refStep(DEF_SEED, 1'b0), "R5 R3 shift after zero seed",
          stateOut, refStep(DEF_SEED, 1'b0));

    // R4: back-to-back loads, second one wins; load holds off the shift
    roleSel = 1'b1; seedLoad = 1'b1; seedVal = 33'h0_1234_5678;
    tick();
    seedVal = 33'h1_8765_4321;
    tick();
    seedLoad = 1'b0;
    check(stateOut == 33'h1_8765_4321, "R4 load priority", stateOut, 33'h1_8765_4321);

    // long reference runs
    refRun(1'b1, 33'h1_DEAD_BEEF, "R2");
    refRun(1'b0, 33'h0_0000_0001, "R3");

    // R1: mid-run reset captures slave role
    rstN = 1'b0; roleSel = 1'b0;
    tick();
    rstN = 1'b1; roleSel = 1'b1;
    check(stateOut == DEF_SEED, "R1 mid-run reset", stateOut, DEF_SEED);
    tick();
    check(stateOut == refStep(DEF_SEED, 1'b0), "R1 R3 role captured in reset",
          stateOut, refStep(DEF_SEED, 1'b0));

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule